// File: doc/BRIEF.md
# OSD Blink and Output Polarity Control

This block sits at the end of an on-screen display pipeline. It takes the raw fast-blanking, half-tone, colour and intensity signals and sets the active level of each one from a configuration register. It conditions the line flyback input to an active-high internal level, and counts frame strobes to produce a blink enable. The blink enable stays on for three times as long as it stays off. A two-bit rate code scales both phase lengths by a power of two.

A small register bus with address, write strobe, write data and combinational read data gives access to two registers. The configuration register at address 0 holds the polarity and half-tone selects. The control/status register at address 1 holds the blink enable, the rate code and five sticky event flags. Software clears a flag by writing 0 to its bit. Writing 1 to a flag bit leaves it unchanged. The frame strobe sets flag 4, and four event inputs set flags 3 to 0.

Top module: `osd_output_ctl`

## Requirements
- R1: After reset both registers read 0x00 and `blink_o` is 1.
- R2: With the blink enabled, `blink_o` is 1 for 24·2^rate frame strobes, then 0 for 8·2^rate strobes, and repeats. The rate code sits in bits 6:5 of address 1. Each strobe is a cycle with `frame_i` high, and the output changes in the cycle after the strobe that ends a phase.
- R3: A write to address 1 whose rate code differs from the stored one restarts the count at the first strobe of the on phase. A write that keeps the same code does not disturb the count.
- R4: While blink enable (address 1, bit 7) is 0, `blink_o` is 1.
- R5: Address 0 holds these bits: bit 0 flyback invert, bit 1 fast-blank invert, bit 2 half-tone invert, bit 3 colour invert, bit 4 intensity invert, bit 5 half-tone enable and bit 6 port value. Bit 7 reads 0. `fb_o`, each line of `rgb_o` and `int_o` equal their raw input XOR their invert bit, so a 1 selects an active-low pin.
- R6: When half-tone enable is 1, `ht_o` is `ht_i` XOR the half-tone invert bit. When it is 0, `ht_o` equals the port value bit, and the invert bit has no effect.
- R7: `flyback_o` is `flyback_i` XOR the flyback invert bit, so with the bit set a low pin reads as an active flyback.
- R8: Address 1 bits 4:0 are sticky flags. A cycle with `frame_i` high sets bit 4, and `evt_i[k]` sets bit k.
- R9: A write to address 1 stores bits 7:5 as written. It clears each flag whose written bit is 0 and leaves each flag whose written bit is 1.
- R10: When a set event and a clearing write hit the same flag in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| frame_i | input | 1 | One-cycle frame strobe |
| evt_i | input | 4 | Event set inputs for flags 3:0 |
| flyback_i | input | 1 | Line flyback pin |
| flyback_o | output | 1 | Flyback, active high |
| fb_i | input | 1 | Raw fast blanking |
| ht_i | input | 1 | Raw half tone |
| rgb_i | input | RGB_W | Raw colour lines |
| int_i | input | 1 | Raw intensity |
| fb_o | output | 1 | Fast-blanking pin |
| ht_o | output | 1 | Shared half-tone / port pin |
| rgb_o | output | RGB_W | Colour pins |
| int_o | output | 1 | Intensity pin |
| blink_o | output | 1 | Blink enable |

## Verification
The blink timer runs at every rate code for two full periods. A tight count error then shows up in the first phase, and a drift shows up in the second. A rate change in mid-phase separates a restart from a timer that carries on. A same-code write made during the off phase separates a timer that ignores the write from one that restarts anyway. The polarity stage is swept over all 128 configuration values against all 128 raw input patterns, which shows a swapped invert bit or a missing enable gate. The flag tests use chosen set/clear patterns: a written 1, a single written 0, and a clear that meets a set in the same cycle.

// File: rtl/osd_ctl_pkg.sv
package osd_ctl_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;
    localparam int RATE_W = 2;
    localparam int EVT_W  = 4;
    localparam int FLAG_W = EVT_W + 1;

    localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;

    // Configuration register, bit 0 at the bottom of the struct
    typedef struct packed {
        logic port_val;   // bit 6
        logic ht_en;      // bit 5
        logic int_inv;    // bit 4
        logic rgb_inv;    // bit 3
        logic ht_inv;     // bit 2
        logic fb_inv;     // bit 1
        logic fly_inv;    // bit 0
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    // Control field of the status register (bits 7:5)
    typedef struct packed {
        logic              blink_en;
        logic [RATE_W-1:0] rate;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/osd_cfg_reg.sv
module osd_cfg_reg
    import osd_ctl_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output cfg_t             cfg_o
);

    typedef struct packed {
        cfg_t cfg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.cfg = cfg_t'(wdata_i[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;

endmodule

// File: rtl/osd_stat_reg.sv
module osd_stat_reg
    import osd_ctl_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              frame_i,
    input  logic [EVT_W-1:0]  evt_i,
    output ctl_t              ctl_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              restart_o
);

    typedef struct packed {
        ctl_t              ctl;
        logic [FLAG_W-1:0] flags;
    } state_t;

    state_t            st_d, st_q;
    logic [FLAG_W-1:0] keep_mask;
    logic [FLAG_W-1:0] set_mask;
    ctl_t              wr_ctl;

    assign wr_ctl   = ctl_t'(wdata_i[REG_W-1 -: CTL_W]);
    assign set_mask = {frame_i, evt_i};

    always_comb begin
        st_d      = st_q;
        keep_mask = wr_i ? wdata_i[FLAG_W-1:0] : '1;
        if (wr_i) begin
            st_d.ctl = wr_ctl;
        end
        // set events are applied after the clear, so they win
        st_d.flags = (st_q.flags & keep_mask) | set_mask;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o     = st_q.ctl;
    assign flags_o   = st_q.flags;
    assign restart_o = wr_i && (wr_ctl.rate != st_q.ctl.rate);

endmodule

// File: rtl/osd_blink_timer.sv
module osd_blink_timer #(
    parameter int BASE_ON  = 24,
    parameter int BASE_OFF = 8,
    parameter int RATE_W   = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              restart_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              on_o
);

    localparam int MAX_SHIFT = (1 << RATE_W) - 1;
    localparam int MAX_LIM   = (BASE_ON > BASE_OFF ? BASE_ON : BASE_OFF) << MAX_SHIFT;
    localparam int LIM_W     = $clog2(MAX_LIM + 1);

    typedef struct packed {
        logic             on;
        logic [LIM_W-1:0] cnt;
    } state_t;

    state_t           st_d, st_q;
    logic [LIM_W-1:0] on_lim;
    logic [LIM_W-1:0] off_lim;
    logic [LIM_W-1:0] last;

    assign on_lim  = LIM_W'(BASE_ON)  << rate_i;
    assign off_lim = LIM_W'(BASE_OFF) << rate_i;
    assign last    = (st_q.on ? on_lim : off_lim) - LIM_W'(1);

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.on  = 1'b1;
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == last) begin
                st_d.on  = !st_q.on;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + LIM_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.on  <= 1'b1;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign on_o = st_q.on;

endmodule

// File: rtl/osd_pol_out.sv
module osd_pol_out
    import osd_ctl_pkg::*;
#(
    parameter int RGB_W = 3
) (
    input  cfg_t             cfg_i,
    input  logic             flyback_i,
    input  logic             fb_i,
    input  logic             ht_i,
    input  logic [RGB_W-1:0] rgb_i,
    input  logic             int_i,
    output logic             flyback_o,
    output logic             fb_o,
    output logic             ht_o,
    output logic [RGB_W-1:0] rgb_o,
    output logic             int_o
);

    assign flyback_o = flyback_i ^ cfg_i.fly_inv;
    assign fb_o      = fb_i ^ cfg_i.fb_inv;
    assign int_o     = int_i ^ cfg_i.int_inv;
    assign ht_o      = cfg_i.ht_en ? (ht_i ^ cfg_i.ht_inv) : cfg_i.port_val;

    for (genvar g = 0; g < RGB_W; g++) begin : g_rgb
        assign rgb_o[g] = rgb_i[g] ^ cfg_i.rgb_inv;
    end

endmodule

// File: rtl/osd_output_ctl.sv
module osd_output_ctl
    import osd_ctl_pkg::*;
#(
    parameter int BASE_ON  = 24,
    parameter int BASE_OFF = 8,
    parameter int RGB_W    = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    input  logic              frame_i,
    input  logic [3:0]        evt_i,
    input  logic              flyback_i,
    output logic              flyback_o,
    input  logic              fb_i,
    input  logic              ht_i,
    input  logic [RGB_W-1:0]  rgb_i,
    input  logic              int_i,
    output logic              fb_o,
    output logic              ht_o,
    output logic [RGB_W-1:0]  rgb_o,
    output logic              int_o,
    output logic              blink_o
);

    cfg_t              cfg;
    ctl_t              ctl;
    logic [FLAG_W-1:0] stat_flags;
    logic              restart;
    logic              phase_on;
    logic              wr_cfg;
    logic              wr_stat;

    assign wr_cfg  = reg_wr_i && (reg_addr_i == ADDR_CFG);
    assign wr_stat = reg_wr_i && (reg_addr_i == ADDR_STAT);

    osd_cfg_reg u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_cfg),
        .wdata_i (reg_wdata_i),
        .cfg_o   (cfg)
    );

    osd_stat_reg u_stat (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr_stat),
        .wdata_i   (reg_wdata_i),
        .frame_i   (frame_i),
        .evt_i     (evt_i),
        .ctl_o     (ctl),
        .flags_o   (stat_flags),
        .restart_o (restart)
    );

    osd_blink_timer #(
        .BASE_ON  (BASE_ON),
        .BASE_OFF (BASE_OFF),
        .RATE_W   (RATE_W)
    ) u_blink (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (frame_i),
        .restart_i (restart),
        .rate_i    (ctl.rate),
        .on_o      (phase_on)
    );

    osd_pol_out #(
        .RGB_W (RGB_W)
    ) u_pol (
        .cfg_i     (cfg),
        .flyback_i (flyback_i),
        .fb_i      (fb_i),
        .ht_i      (ht_i),
        .rgb_i     (rgb_i),
        .int_i     (int_i),
        .flyback_o (flyback_o),
        .fb_o      (fb_o),
        .ht_o      (ht_o),
        .rgb_o     (rgb_o),
        .int_o     (int_o)
    );

    assign blink_o = !ctl.blink_en || phase_on;

    always_comb begin
        unique case (reg_addr_i)
            ADDR_CFG:  reg_rdata_o = REG_W'(cfg);
            ADDR_STAT: reg_rdata_o = {ctl, stat_flags};
            default:   reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/osd_output_ctl_chk.sv
module osd_output_ctl_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       reg_wr_i,
    input logic [1:0] reg_addr_i,
    input logic       frame_i,
    input logic [3:0] evt_i,
    input logic [4:0] flags,
    input logic       blink_en,
    input logic       blink_o,
    input logic       ht_en,
    input logic       port_val,
    input logic       ht_o
);

    logic stat_wr;
    assign stat_wr = reg_wr_i && (reg_addr_i == 2'd1);

    // R8: flags never drop without a write to the status register
    assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(stat_wr) |-> ((flags & $past(flags)) == $past(flags)));

    // R8: every event input lands in its flag
    assert_evt_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i != 4'd0) |=> ((flags[3:0] & $past(evt_i)) == $past(evt_i)));

    // R10: frame strobe sets its flag even against a clearing write
    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_i |=> flags[4]);

    // R4: disabled blink holds the output on
    assert_blink_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !blink_en |-> blink_o);

    // R2: blink only moves on a strobe or a register write
    assert_blink_still_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!frame_i && !reg_wr_i) |=> $stable(blink_o));

    // R6: disabled half tone hands the pin to the port value
    assert_ht_port_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ht_en |-> (ht_o == port_val));

endmodule

bind osd_output_ctl osd_output_ctl_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .frame_i    (frame_i),
    .evt_i      (evt_i),
    .flags      (stat_flags),
    .blink_en   (ctl.blink_en),
    .blink_o    (blink_o),
    .ht_en      (cfg.ht_en),
    .port_val   (cfg.port_val),
    .ht_o       (ht_o)
);

// File: tb/osd_output_ctl_bench.sv
module osd_output_ctl_bench;

    localparam int RGB_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_addr = '0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic             frame = 1'b0;
    logic [3:0]       evt = '0;
    logic             flyback_in = 1'b0;
    logic             flyback_out;
    logic             fb_in = 1'b0, ht_in = 1'b0, int_in = 1'b0;
    logic [RGB_W-1:0] rgb_in = '0;
    logic             fb_out, ht_out, int_out, blink;
    logic [RGB_W-1:0] rgb_out;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    typedef struct {
        logic  val;
        string req;
    } exp_t;
    exp_t sb[$];

    // bench-side blink model state
    int   m_on = 1, m_cnt = 0, m_rate = 0, m_en = 0;

    always #10 clk = ~clk;

    osd_output_ctl #(.RGB_W(RGB_W)) u_osd_output_ctl (
        .clk_i(clk), .rst_ni(rst_n),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .frame_i(frame), .evt_i(evt),
        .flyback_i(flyback_in), .flyback_o(flyback_out),
        .fb_i(fb_in), .ht_i(ht_in), .rgb_i(rgb_in), .int_i(int_in),
        .fb_o(fb_out), .ht_o(ht_out), .rgb_o(rgb_out), .int_o(int_out),
        .blink_o(blink)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr_stat(logic [7:0] d);
        if (int'(d[6:5]) != m_rate) begin
            m_on = 1; m_cnt = 0;
        end
        m_rate = int'(d[6:5]);
        m_en   = int'(d[7]);
        wr(2'd1, d);
    endtask

    task automatic rd_check(string req, logic [1:0] a, logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, 32'(reg_rdata), 32'(exp));
    endtask

    // driver: one frame strobe, expected blink pushed to the scoreboard
    task automatic strobe(string req);
        exp_t e;
        int   lim;
        @(negedge clk);
        frame = 1'b1;
        lim = m_on ? (24 << m_rate) : (8 << m_rate);
        if (m_cnt == lim - 1) begin
            m_on = 1 - m_on; m_cnt = 0;
        end else begin
            m_cnt++;
        end
        e.val = (m_en == 0) ? 1'b1 : m_on[0];
        e.req = req;
        sb.push_back(e);
        @(negedge clk);
        frame = 1'b0;
    endtask

    // monitor: compares the cycle after each strobe
    initial begin
        forever begin
            exp_t e;
            wait (sb.size() > 0);
            @(negedge clk);
            e = sb.pop_front();
            check(e.req, 32'(blink), 32'(e.val));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_check("R1 cfg reset", 2'd0, 8'h00);
        rd_check("R1 stat reset", 2'd1, 8'h00);
        check("R1 blink reset", 32'(blink), 32'd1);

        // R5 R6 R7 polarity sweep
        for (int m = 0; m < 128; m++) begin
            wr(2'd0, 8'(m));
            rd_check("R5 cfg readback", 2'd0, 8'(m));
            for (int r = 0; r < 128; r++) begin
                logic [6:0] rv;
                logic [6:0] mv;
                rv = 7'(r);
                mv = 7'(m);
                {flyback_in, fb_in, ht_in, rgb_in, int_in} = rv;
                #1;
                check("R5", {fb_out, rgb_out, int_out},
                      {mv[1] ^ rv[5], rgb_in ^ {RGB_W{mv[3]}}, mv[4] ^ rv[0]});
                check("R6", 32'(ht_out), 32'(mv[5] ? (rv[4] ^ mv[2]) : mv[6]));
                check("R7", 32'(flyback_out), 32'(rv[6] ^ mv[0]));
            end
        end

        // R8 event and frame flags
        @(negedge clk); evt = 4'b0101;
        @(negedge clk); evt = 4'b0000;
        rd_check("R8 evt flags", 2'd1, 8'h05);
        strobe("R4 strobe while disabled");
        wait (sb.size() == 0);
        rd_check("R8 frame flag", 2'd1, 8'h15);

        // R9 write-one keeps, write-zero clears
        wr_stat(8'h1F);
        rd_check("R9 write ones keep", 2'd1, 8'h15);
        wr_stat(8'h1B);
        rd_check("R9 single clear", 2'd1, 8'h11);

        // R10 set beats clear
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h00; evt = 4'b0010;
        @(negedge clk);
        reg_wr = 1'b0; evt = 4'b0000;
        rd_check("R10 set wins", 2'd1, 8'h02);

        // R9 control bits readback
        wr_stat(8'hA0);
        rd_check("R9 control bits", 2'd1, 8'hA0);
        wr_stat(8'h00);
        rd_check("R9 control clear", 2'd1, 8'h00);

        // R2 each rate code over two periods
        wr_stat(8'hA0);
        for (int i = 0; i < 128; i++) strobe("R2 rate 1");
        wr_stat(8'hC0);
        for (int i = 0; i < 256; i++) strobe("R2 rate 2");
        wr_stat(8'hE0);
        for (int i = 0; i < 512; i++) strobe("R2 rate 3");
        wr_stat(8'h80);
        for (int i = 0; i < 74; i++) strobe("R2 rate 0");

        // R3 mid-phase rate change restarts
        wr_stat(8'hA0);
        check("R3 restart on", 32'(blink), 32'd1);
        for (int i = 0; i < 50; i++) strobe("R3 after restart");
        wait (sb.size() == 0);
        check("R3 in off phase", 32'(blink), 32'd0);

        // R4 disable forces on, same code keeps count
        wr_stat(8'h20);
        check("R4 disabled", 32'(blink), 32'd1);
        wr_stat(8'hA0);
        check("R3 same code no restart", 32'(blink), 32'd0);
        for (int i = 0; i < 16; i++) strobe("R3 count kept");
        wait (sb.size() == 0);

        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule